// File: doc/BRIEF.md
# Double-Banked Configuration Register Unit

This unit owns the configuration state that steers a processing pipeline. It has two parts. The first is a configuration store of 32-bit words that every thread shares. It is kept in two banks, so software can prepare one bank while the hardware runs from the other. The second is a small per-thread store of 16-bit entries. One entry of that per-thread store is the bank selector: its bit 0 picks the bank that thread's operations address.

Three threads issue 32-bit instructions into the unit, each on its own valid/instruction pair. Four operations go through one shared path, which accepts at most one instruction per cycle and picks among the threads in round-robin order:

- a 32-bit or 128-bit copy from general-purpose registers into the store,
- a 32-bit read back into a register,
- a masked write to one byte.

A thread-local 16-bit write uses a path of its own and is accepted at once.

The thread supplies the register contents as the aligned group of four registers that holds the named register. Read results return on a write-back port. A per-thread pending flag lets the issuing thread stall until its result has landed. Words at or above a global base index are written into both banks. A full-word write to the state-clear index wipes the non-global words of its bank.

Top module: `cfg_bank_unit`

## Requirements
- R1: Opcode 0xB0 with bit 15 clear writes one word. The register index sits in bits [21:16], and its low two bits pick the 32-bit lane of the supplied group (lane k is bits 32k+31:32k). The word index is the low log2(CFG_DEPTH) bits of [10:0], taken in the issuing thread's active bank. A read accepted in a later cycle returns the new value.
- R2: Opcode 0xB0 with bit 15 set clears the low two bits of the word index and copies lanes 0 to 3 of the group into the four consecutive words starting there.
- R3: Opcode 0xB1 returns, two clock edges after its acceptance edge, one cycle of write-back. That cycle carries the issuing thread, the register index from bits [21:16], and the word at the low index bits of [15:0] in the thread's active bank.
- R4: Opcode 0xB2 writes the 16-bit value in [15:0] to entry [23:16] (modulo TCFG_DEPTH) of the issuing thread only. It is accepted in the cycle it is presented, even when all threads present one together. Bit 0 of entry BANKSEL_IDX is that thread's active bank. Other entries leave the bank unchanged.
- R5: Opcodes 0xB3 to 0xB6 update byte lane (opcode - 0xB3) of the word at the index in [7:0]. The new byte is (data[15:8] AND mask[23:16]) OR (old byte AND NOT mask). Every other bit of the word keeps its value.
- R6: Word writes and byte updates at an index of GLOBAL_BASE or above change both banks identically.
- R7: A word write (32- or 128-bit) that covers RESET_IDX clears every word below GLOBAL_BASE in the addressed bank. Global words and the other bank are kept. A byte update at RESET_IDX clears nothing.
- R8: The shared path grants at most one thread per cycle, in round-robin order starting after the last granted thread. After reset, thread 0 has first priority.
- R9: The pending flag of a thread is high from the cycle after its read is accepted up to and including its write-back cycle. Otherwise it is low.
- R10: After reset, every configuration word and every thread entry is zero, so all threads use bank 0. Write-back and pending are low.
- R11: Any other opcode is accepted in the cycle it is presented and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid_i | input | NTHR | Per-thread instruction valid, held until accepted |
| instr_i | input | NTHR x 32 | Per-thread instruction word |
| gpr_group_i | input | NTHR x 128 | Per-thread aligned group of four registers holding the named register |
| accept_o | output | NTHR | Instruction of that thread is taken at the coming clock edge |
| rd_pending_o | output | NTHR | Read write-back outstanding for that thread |
| wb_valid_o | output | 1 | Read result valid this cycle |
| wb_thread_o | output | log2(NTHR) | Thread the read result belongs to |
| wb_gpr_o | output | 6 | Destination register index |
| wb_data_o | output | 32 | Read result |

## Verification
Acceptance is combinational, so the bench samples it 1 ns after driving its inputs on the falling edge. A store update becomes visible to a read presented one cycle after the write is accepted. A read's write-back appears on the second falling edge after its acceptance edge, and the pending flag is already high at the first. The bench therefore checks write-back and pending on exactly those falling edges. It also checks on the next falling edge that both have dropped. In the simultaneous-request test the three results are expected on three consecutive falling edges, in the order of the grants.

// File: rtl/cfg_unit_pkg.sv
`timescale 1ns/1ps
package cfg_unit_pkg;

  localparam logic [7:0] OPC_CFG_WR  = 8'hB0;
  localparam logic [7:0] OPC_CFG_RD  = 8'hB1;
  localparam logic [7:0] OPC_TCFG_WR = 8'hB2;
  localparam logic [7:0] OPC_RMW_LO  = 8'hB3;
  localparam logic [7:0] OPC_RMW_HI  = 8'hB6;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0,
    SH_WR   = 2'd1,
    SH_RD   = 2'd2,
    SH_RMW  = 2'd3
  } sh_kind_e;

  // Classify an opcode for the shared (one-per-cycle) path.
  function automatic sh_kind_e decode_shared(input logic [7:0] opc);
    if (opc == OPC_CFG_WR)                          return SH_WR;
    else if (opc == OPC_CFG_RD)                     return SH_RD;
    else if (opc >= OPC_RMW_LO && opc <= OPC_RMW_HI) return SH_RMW;
    else                                            return SH_NONE;
  endfunction

endpackage

// File: rtl/cfg_rr_arb.sv
`timescale 1ns/1ps
module cfg_rr_arb #(
  parameter int N = 3,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);

  logic [PW-1:0] last_q, last_d;

  // Search starts one position after the last winner.
  always_comb begin
    int idx;
    gnt    = '0;
    last_d = last_q;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last_q) + k) % N;
      if (gnt == '0 && req[idx]) begin
        gnt[idx] = 1'b1;
        last_d   = PW'(idx);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    last_q <= PW'(N - 1);
    else if (|req) last_q <= last_d;
  end

  assert_gnt_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_gnt_only_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

  // A thread may win twice in a row only when nobody else is asking.
  assert_rr_fair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|gnt && gnt == $past(gnt)) |-> (req & ~gnt) == '0);

endmodule

// File: rtl/cfg_tstore.sv
`timescale 1ns/1ps
module cfg_tstore #(
  parameter int N           = 3,
  parameter int DEPTH       = 8,
  parameter int BANKSEL_IDX = 0,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N-1:0]       we,
  input  logic [N-1:0][7:0]  idx,
  input  logic [N-1:0][15:0] val,
  output logic [N-1:0]       bank
);

  for (genvar t = 0; t < N; t++) begin : g_thr
    logic [15:0] ent_q [DEPTH];
    logic [15:0] ent_d [DEPTH];

    always_comb begin
      ent_d = ent_q;
      if (we[t]) ent_d[idx[t][IW-1:0]] = val[t];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int e = 0; e < DEPTH; e++) ent_q[e] <= '0;
      end else if (we[t]) begin
        ent_q <= ent_d;
      end
    end

    assign bank[t] = ent_q[BANKSEL_IDX][0];

    assert_banksel_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (we[t] && idx[t][IW-1:0] == IW'(BANKSEL_IDX)) |=> bank[t] == $past(val[t][0]));
  end

endmodule

// File: rtl/cfg_store.sv
`timescale 1ns/1ps
module cfg_store #(
  parameter int DEPTH       = 64,
  parameter int GLOBAL_BASE = 48,
  parameter int RESET_IDX   = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rmw_en,
  input  logic          bank,
  input  logic          wide,
  input  logic [AW-1:0] cidx,
  input  logic [1:0]    lane,
  input  logic [127:0]  wdata,
  input  logic [7:0]    mask,
  input  logic [7:0]    mbyte,
  input  logic          rd_bank,
  input  logic [AW-1:0] rd_idx,
  output logic [31:0]   rd_data
);

  logic [31:0] mem_q [2][DEPTH];
  logic [31:0] mem_d [2][DEPTH];
  logic        clr_hit;
  logic [7:0]  old_byte;

  assign clr_hit  = wide ? ((cidx >> 2) == (AW'(RESET_IDX) >> 2)) : (cidx == AW'(RESET_IDX));
  assign old_byte = mem_q[bank][cidx][{lane, 3'b000} +: 8];

  always_comb begin
    logic sel, hit;
    mem_d = mem_q;
    for (int b = 0; b < 2; b++) begin
      for (int w = 0; w < DEPTH; w++) begin
        sel = (b == int'(bank)) || (w >= GLOBAL_BASE);
        hit = wide ? ((AW'(w) >> 2) == (cidx >> 2)) : (AW'(w) == cidx);
        if (wr_en && sel && hit)
          mem_d[b][w] = wide ? wdata[32*(w%4) +: 32] : wdata[{lane, 5'b00000} +: 32];
        if (rmw_en && sel && AW'(w) == cidx)
          mem_d[b][w][{lane, 3'b000} +: 8] = (mbyte & mask) | (old_byte & ~mask);
        if (wr_en && clr_hit && b == int'(bank) && w < GLOBAL_BASE)
          mem_d[b][w] = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < 2; b++)
        for (int w = 0; w < DEPTH; w++) mem_q[b][w] <= '0;
    end else if (wr_en || rmw_en) begin
      mem_q <= mem_d;
    end
  end

  assign rd_data = mem_q[rd_bank][rd_idx];

  // Checker state: snapshot of the last committed operation.
  logic          chk_g_v, chk_c_v, chk_c_b, chk_r_v, chk_r_b;
  logic [AW-1:0] chk_g_idx, chk_r_idx;
  logic [1:0]    chk_r_lane;
  logic [7:0]    chk_r_mask, chk_r_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_g_v <= 1'b0; chk_c_v <= 1'b0; chk_c_b <= 1'b0; chk_r_v <= 1'b0; chk_r_b <= 1'b0;
      chk_g_idx <= '0; chk_r_idx <= '0; chk_r_lane <= '0; chk_r_mask <= '0; chk_r_old <= '0;
    end else begin
      chk_g_v    <= wr_en && !wide && int'(cidx) >= GLOBAL_BASE;
      chk_g_idx  <= cidx;
      chk_c_v    <= wr_en && clr_hit;
      chk_c_b    <= bank;
      chk_r_v    <= rmw_en;
      chk_r_b    <= bank;
      chk_r_idx  <= cidx;
      chk_r_lane <= lane;
      chk_r_mask <= mask;
      chk_r_old  <= old_byte;
    end
  end

  assert_global_both_banks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_g_v |-> mem_q[0][chk_g_idx] == mem_q[1][chk_g_idx]);

  assert_state_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_c_v |-> mem_q[chk_c_b][0] == '0);

  assert_rmw_unmasked_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chk_r_v |-> ((mem_q[chk_r_b][chk_r_idx][{chk_r_lane, 3'b000} +: 8] ^ chk_r_old) & ~chk_r_mask) == '0);

endmodule

// File: rtl/cfg_bank_unit.sv
`timescale 1ns/1ps
module cfg_bank_unit
  import cfg_unit_pkg::*;
#(
  parameter int NTHR        = 3,
  parameter int CFG_DEPTH   = 64,
  parameter int GLOBAL_BASE = 48,
  parameter int RESET_IDX   = 4,
  parameter int TCFG_DEPTH  = 8,
  parameter int BANKSEL_IDX = 0,
  localparam int AW = $clog2(CFG_DEPTH),
  localparam int TW = (NTHR > 1) ? $clog2(NTHR) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NTHR-1:0]         instr_valid_i,
  input  logic [NTHR-1:0][31:0]   instr_i,
  input  logic [NTHR-1:0][127:0]  gpr_group_i,
  output logic [NTHR-1:0]         accept_o,
  output logic [NTHR-1:0]         rd_pending_o,
  output logic                    wb_valid_o,
  output logic [TW-1:0]           wb_thread_o,
  output logic [5:0]              wb_gpr_o,
  output logic [31:0]             wb_data_o
);

  sh_kind_e                kind [NTHR];
  logic [NTHR-1:0]         sh_req, arb_gnt, tc_we, bank_sel;
  logic [NTHR-1:0][7:0]    tc_idx;
  logic [NTHR-1:0][15:0]   tc_val;

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      kind[t]     = decode_shared(instr_i[t][31:24]);
      sh_req[t]   = instr_valid_i[t] && kind[t] != SH_NONE;
      tc_we[t]    = instr_valid_i[t] && instr_i[t][31:24] == OPC_TCFG_WR;
      tc_idx[t]   = instr_i[t][23:16];
      tc_val[t]   = instr_i[t][15:0];
      accept_o[t] = instr_valid_i[t] && (kind[t] == SH_NONE || arb_gnt[t]);
    end
  end

  cfg_rr_arb #(.N(NTHR)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(sh_req), .gnt(arb_gnt)
  );

  cfg_tstore #(.N(NTHR), .DEPTH(TCFG_DEPTH), .BANKSEL_IDX(BANKSEL_IDX)) u_tstore (
    .clk(clk), .rst_n(rst_n), .we(tc_we), .idx(tc_idx), .val(tc_val), .bank(bank_sel)
  );

  // Issue stage: the granted shared-path instruction, one cycle before commit.
  logic          st_vld_q, st_vld_d, st_bank_q, st_bank_d, st_wide_q, st_wide_d;
  sh_kind_e      st_kind_q, st_kind_d;
  logic [TW-1:0] st_thr_q, st_thr_d;
  logic [AW-1:0] st_cidx_q, st_cidx_d;
  logic [1:0]    st_lane_q, st_lane_d;
  logic [5:0]    st_gpr_q, st_gpr_d;
  logic [7:0]    st_mask_q, st_mask_d, st_byte_q, st_byte_d;
  logic [127:0]  st_data_q, st_data_d;

  always_comb begin
    st_vld_d  = |arb_gnt;
    st_kind_d = SH_NONE; st_thr_d = '0; st_bank_d = 1'b0; st_wide_d = 1'b0;
    st_cidx_d = '0; st_lane_d = '0; st_gpr_d = '0; st_mask_d = '0; st_byte_d = '0;
    st_data_d = '0;
    for (int t = 0; t < NTHR; t++) begin
      if (arb_gnt[t]) begin
        st_kind_d = kind[t];
        st_thr_d  = TW'(t);
        st_bank_d = bank_sel[t];
        st_wide_d = (kind[t] == SH_WR) && instr_i[t][15];
        st_cidx_d = instr_i[t][AW-1:0];
        st_gpr_d  = instr_i[t][21:16];
        // Byte update: opcodes B3..B6 end in 11,00,01,10, so +1 gives lane 0..3.
        st_lane_d = (kind[t] == SH_RMW) ? instr_i[t][25:24] + 2'd1 : instr_i[t][17:16];
        st_mask_d = instr_i[t][23:16];
        st_byte_d = instr_i[t][15:8];
        st_data_d = gpr_group_i[t];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_vld_q <= 1'b0; st_kind_q <= SH_NONE; st_thr_q <= '0; st_bank_q <= 1'b0;
      st_wide_q <= 1'b0; st_cidx_q <= '0; st_lane_q <= '0; st_gpr_q <= '0;
      st_mask_q <= '0; st_byte_q <= '0; st_data_q <= '0;
    end else begin
      st_vld_q <= st_vld_d;
      if (st_vld_d) begin
        st_kind_q <= st_kind_d; st_thr_q <= st_thr_d; st_bank_q <= st_bank_d;
        st_wide_q <= st_wide_d; st_cidx_q <= st_cidx_d; st_lane_q <= st_lane_d;
        st_gpr_q <= st_gpr_d; st_mask_q <= st_mask_d; st_byte_q <= st_byte_d;
        st_data_q <= st_data_d;
      end
    end
  end

  logic        st_wr, st_rmw, st_rd;
  logic [31:0] rd_word;

  assign st_wr  = st_vld_q && st_kind_q == SH_WR;
  assign st_rmw = st_vld_q && st_kind_q == SH_RMW;
  assign st_rd  = st_vld_q && st_kind_q == SH_RD;

  cfg_store #(.DEPTH(CFG_DEPTH), .GLOBAL_BASE(GLOBAL_BASE), .RESET_IDX(RESET_IDX)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(st_wr), .rmw_en(st_rmw), .bank(st_bank_q),
    .wide(st_wide_q), .cidx(st_cidx_q), .lane(st_lane_q), .wdata(st_data_q),
    .mask(st_mask_q), .mbyte(st_byte_q), .rd_bank(st_bank_q), .rd_idx(st_cidx_q),
    .rd_data(rd_word)
  );

  // Write-back register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid_o <= 1'b0; wb_thread_o <= '0; wb_gpr_o <= '0; wb_data_o <= '0;
    end else begin
      wb_valid_o <= st_rd;
      if (st_rd) begin
        wb_thread_o <= st_thr_q;
        wb_gpr_o    <= st_gpr_q;
        wb_data_o   <= rd_word;
      end
    end
  end

  always_comb begin
    for (int t = 0; t < NTHR; t++)
      rd_pending_o[t] = (st_rd && st_thr_q == TW'(t)) || (wb_valid_o && wb_thread_o == TW'(t));
  end

  for (genvar t = 0; t < NTHR; t++) begin : g_chk
    assert_read_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_o[t] && kind[t] == SH_RD) |=> rd_pending_o[t]);
    assert_read_wb_due_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_o[t] && kind[t] == SH_RD) |=> ##1 (wb_valid_o && wb_thread_o == TW'(t)));
  end

endmodule

// File: tb/cfg_bank_unit_test.sv
`timescale 1ns/1ps
module cfg_bank_unit_test;

  localparam int NT = 3, DEP = 64, GB = 48, RST = 4, TCD = 8, BS = 0;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic [NT-1:0]         vld;
  logic [NT-1:0][31:0]   ins;
  logic [NT-1:0][127:0]  gdat;
  logic [NT-1:0]         acc, pend;
  logic                  wbv;
  logic [1:0]            wbt;
  logic [5:0]            wbg;
  logic [31:0]           wbd;

  always #10 clk = ~clk;

  cfg_bank_unit #(.NTHR(NT), .CFG_DEPTH(DEP), .GLOBAL_BASE(GB), .RESET_IDX(RST),
                  .TCFG_DEPTH(TCD), .BANKSEL_IDX(BS)) uut (
    .clk(clk), .rst_n(rst_n), .instr_valid_i(vld), .instr_i(ins), .gpr_group_i(gdat),
    .accept_o(acc), .rd_pending_o(pend), .wb_valid_o(wbv), .wb_thread_o(wbt),
    .wb_gpr_o(wbg), .wb_data_o(wbd)
  );

  int n_vec = 0, n_bad = 0;
  logic [31:0] mcfg [2][DEP];
  int          mbank [NT];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_wr(logic [5:0] g, bit wide, logic [10:0] c);
    return {8'hB0, 2'b00, g, wide, 4'b0000, c};
  endfunction
  function automatic logic [31:0] enc_rd(logic [5:0] g, logic [10:0] c);
    return {8'hB1, 2'b00, g, 5'b00000, c};
  endfunction
  function automatic logic [31:0] enc_tc(logic [7:0] i, logic [15:0] v);
    return {8'hB2, i, v};
  endfunction
  function automatic logic [31:0] enc_rmw(logic [1:0] ln, logic [7:0] m, logic [7:0] d, logic [7:0] i);
    return {8'hB3 + {6'd0, ln}, m, d, i};
  endfunction

  // Reference model of the store.
  function automatic void put(int b, int w, logic [31:0] v);
    mcfg[b][w] = v;
    if (w >= GB) mcfg[1-b][w] = v;
  endfunction

  function automatic void m_wr(int t, logic [10:0] c11, logic [5:0] g, bit wide, logic [127:0] d);
    int b = mbank[t];
    int c = int'(c11) % DEP;
    if (wide) begin
      for (int k = 0; k < 4; k++) put(b, (c & ~3) + k, d[32*k +: 32]);
    end else begin
      put(b, c, d[32*int'(g[1:0]) +: 32]);
    end
    if (wide ? (c / 4 == RST / 4) : (c == RST))
      for (int w = 0; w < GB; w++) mcfg[b][w] = '0;
  endfunction

  function automatic void m_rmw(int t, logic [1:0] ln, logic [7:0] m, logic [7:0] d, logic [7:0] i8);
    int c = int'(i8) % DEP;
    for (int b = 0; b < 2; b++) begin
      if (b == mbank[t] || c >= GB)
        mcfg[b][c][8*int'(ln) +: 8] = (d & m) | (mcfg[b][c][8*int'(ln) +: 8] & ~m);
    end
  endfunction

  task automatic issue(int t, logic [31:0] i, logic [127:0] d);
    @(negedge clk);
    vld[t] = 1'b1; ins[t] = i; gdat[t] = d;
    #1;
    while (!acc[t]) begin @(negedge clk); #1; end
    @(posedge clk);
    @(negedge clk);
    vld[t] = 1'b0;
  endtask

  task automatic do_wr(int t, logic [5:0] g, bit wide, logic [10:0] c, logic [127:0] d);
    issue(t, enc_wr(g, wide, c), d);
    m_wr(t, c, g, wide, d);
  endtask

  task automatic do_rmw(int t, logic [1:0] ln, logic [7:0] m, logic [7:0] d, logic [7:0] i8);
    issue(t, enc_rmw(ln, m, d, i8), '0);
    m_rmw(t, ln, m, d, i8);
  endtask

  task automatic do_read(int t, logic [10:0] c, logic [5:0] g, string tag);
    logic [31:0] exp;
    issue(t, enc_rd(g, c), '0);
    chk(pend[t] == 1'b1, "R9 pending after read accept", pend, 1'b1);
    exp = mcfg[mbank[t]][int'(c) % DEP];
    @(negedge clk);
    chk(wbv && wbt == 2'(t) && wbg == g && wbd == exp, tag, {wbv, wbt, wbg, wbd}, {1'b1, 2'(t), g, exp});
    chk(pend[t] == 1'b1, "R9 pending in write-back cycle", pend, 1'b1);
    @(negedge clk);
    chk(!wbv && pend == '0, "R9 pending and write-back cleared", {wbv, pend}, 0);
  endtask

  task automatic tc_write(int t, logic [7:0] i, logic [15:0] v);
    @(negedge clk);
    vld[t] = 1'b1; ins[t] = enc_tc(i, v);
    #1;
    chk(acc[t] == 1'b1, "R4 thread-entry write accepted at once", acc, 1'b1);
    @(posedge clk);
    @(negedge clk);
    vld[t] = 1'b0;
    if (int'(i) % TCD == BS) mbank[t] = int'(v[0]);
  endtask

  initial begin
    #(20ns * 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [127:0] d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; vld = '0; ins = '0; gdat = '0;
    for (int b = 0; b < 2; b++) for (int w = 0; w < DEP; w++) mcfg[b][w] = '0;
    for (int t = 0; t < NT; t++) mbank[t] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(acc == '0 && !wbv && pend == '0, "R10 outputs in reset", {acc, wbv, pend}, 0);
    rst_n = 1'b1;

    // R10: store and bank selectors start at zero
    do_read(0, 11'd5, 6'd1, "R10 word zero after reset");
    do_read(2, 11'd50, 6'd2, "R10 global word zero after reset");

    // R1: single-word write, lane from register index
    d = 128'h44444444_33333333_22222222_11111111;
    do_wr(0, 6'd5, 1'b0, 11'd10, d);
    do_read(0, 11'd10, 6'd7, "R1 word write lane 1");
    do_wr(0, 6'd2, 1'b0, 11'd73, d);
    do_read(0, 11'd9, 6'd8, "R1 index taken modulo depth");

    // R2: 128-bit write to aligned group
    d = 128'hDDDD0003_CCCC0002_BBBB0001_AAAA0000;
    do_wr(0, 6'd9, 1'b1, 11'd13, d);
    for (int k = 12; k < 16; k++) do_read(0, 11'(k), 6'(k), "R2 wide write word");

    // R4: per-thread bank selection
    tc_write(1, 8'(BS), 16'h0001);
    do_wr(1, 6'd0, 1'b0, 11'd20, 128'hB1B1B1B1);
    do_read(0, 11'd20, 6'd3, "R4 thread 0 still on bank 0");
    do_read(1, 11'd20, 6'd3, "R4 thread 1 on bank 1");
    tc_write(1, 8'(BS + 1), 16'h0000);
    do_read(1, 11'd20, 6'd4, "R4 other entry keeps bank");

    // R6: global region written to both banks
    do_wr(0, 6'd0, 1'b0, 11'd50, 128'h5050_5050);
    do_read(1, 11'd50, 6'd5, "R6 global word seen from bank 1");
    do_rmw(1, 2'd2, 8'hFF, 8'h6C, 8'd51);
    do_read(0, 11'd51, 6'd6, "R6 global byte update seen from bank 0");

    // R5: byte updates on each lane
    for (int ln = 0; ln < 4; ln++) begin
      do_rmw(0, 2'(ln), 8'h0F ^ 8'(ln * 8'h11), 8'hA5, 8'd10);
      do_read(0, 11'd10, 6'd9, "R5 masked byte update");
    end
    do_rmw(0, 2'd3, 8'h00, 8'hFF, 8'd10);
    do_read(0, 11'd10, 6'd9, "R5 zero mask changes nothing");

    // R7: state clear
    do_wr(1, 6'd0, 1'b0, 11'd3, 128'h3333_0001);
    do_wr(0, 6'd0, 1'b0, 11'd3, 128'h3333_0000);
    do_wr(1, 6'd0, 1'b0, 11'd49, 128'h4949_0001);
    do_rmw(1, 2'd0, 8'hFF, 8'h77, 8'(RST));
    do_read(1, 11'd3, 6'd10, "R7 byte update at clear index keeps words");
    do_wr(1, 6'd1, 1'b0, 11'(RST), 128'h0_0000_0000_1234_5678_0000_0000);
    do_read(1, 11'd3, 6'd11, "R7 bank 1 low word cleared");
    do_read(1, 11'(RST), 6'd11, "R7 clear index itself cleared");
    do_read(1, 11'd49, 6'd12, "R7 global word kept");
    do_read(0, 11'd3, 6'd13, "R7 other bank kept");
    do_wr(0, 6'd0, 1'b1, 11'(RST + 2), {4{32'hC1EA0000}});
    do_read(0, 11'd3, 6'd14, "R7 wide write covering clear index");

    // R4: all three thread-entry writes in one cycle
    @(negedge clk);
    vld = '1;
    ins[0] = enc_tc(8'(BS), 16'h0000);
    ins[1] = enc_tc(8'(BS), 16'h0001);
    ins[2] = enc_tc(8'd3, 16'h0001);
    #1;
    chk(acc == 3'b111, "R4 three thread-entry writes same cycle", acc, 3'b111);
    @(posedge clk);
    @(negedge clk);
    vld = '0;
    mbank[0] = 0; mbank[1] = 1;
    do_read(1, 11'd20, 6'd15, "R4 thread 1 bank after joint write");
    do_read(2, 11'd20, 6'd15, "R4 thread 2 bank unchanged");

    // R11: unknown opcode
    @(negedge clk);
    vld[0] = 1'b1; ins[0] = 32'h4500_0A0A;
    #1;
    chk(acc[0] == 1'b1, "R11 unknown opcode accepted", acc, 1'b1);
    @(posedge clk);
    @(negedge clk);
    vld[0] = 1'b0;
    chk(!wbv && pend == '0, "R11 unknown opcode no read activity", {wbv, pend}, 0);
    @(negedge clk);
    chk(!wbv, "R11 unknown opcode no write-back", wbv, 0);
    do_read(0, 11'd10, 6'd16, "R11 store unchanged after unknown opcode");

    // R8: simultaneous reads, round-robin order
    do_read(2, 11'd0, 6'd0, "R3 setup read from thread 2");
    @(negedge clk);
    for (int k = 0; k < NT; k++) begin
      ins[k] = enc_rd(6'(40 + k), 11'(10 + 10 * k));
      gdat[k] = '0;
    end
    vld = '1;
    #1;
    chk(acc == 3'b001, "R8 first grant to thread 0", acc, 3'b001);
    @(negedge clk);
    vld[0] = 1'b0;
    #1;
    chk(acc == 3'b010, "R8 second grant to thread 1", acc, 3'b010);
    @(negedge clk);
    vld[1] = 1'b0;
    #1;
    chk(acc == 3'b100, "R8 third grant to thread 2", acc, 3'b100);
    chk(wbv && wbt == 2'd0 && wbg == 6'd40 && wbd == mcfg[mbank[0]][10],
        "R3 thread 0 result first", {wbv, wbt, wbg, wbd}, {1'b1, 2'd0, 6'd40, mcfg[mbank[0]][10]});
    @(negedge clk);
    vld[2] = 1'b0;
    #1;
    chk(wbv && wbt == 2'd1 && wbg == 6'd41 && wbd == mcfg[mbank[1]][20],
        "R3 thread 1 result second", {wbv, wbt, wbg, wbd}, {1'b1, 2'd1, 6'd41, mcfg[mbank[1]][20]});
    @(negedge clk);
    #1;
    chk(wbv && wbt == 2'd2 && wbg == 6'd42 && wbd == mcfg[mbank[2]][30],
        "R3 thread 2 result third", {wbv, wbt, wbg, wbd}, {1'b1, 2'd2, 6'd42, mcfg[mbank[2]][30]});

    // Random traffic against the model
    for (int it = 0; it < 400; it++) begin
      automatic int          t  = $urandom_range(0, NT - 1);
      automatic int          op = $urandom_range(0, 6);
      automatic logic [10:0] c  = 11'($urandom);
      automatic logic [5:0]  g  = 6'($urandom);
      automatic logic [127:0] rd = {$urandom, $urandom, $urandom, $urandom};
      case (op)
        0:       do_wr(t, g, 1'b0, c, rd);
        1:       do_wr(t, g, 1'b1, c, rd);
        2:       do_rmw(t, 2'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
        3, 4, 5: do_read(t, c, g, "R3 random read against model");
        default: tc_write(t, 8'(BS), 16'($urandom));
      endcase
    end

    // Final sweep of both banks
    for (int b = 0; b < 2; b++) begin
      tc_write(0, 8'(BS), 16'(b));
      for (int w = 0; w < DEP; w++) do_read(0, 11'(w), 6'(w), "R1 final sweep of store");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule